// File: doc/BRIEF.md
# Transmit Jabber and Receive Watchdog Guard

This block sits beside an Ethernet MAC datapath and guards both directions of the line. On the transmit side it watches the transmit-enable line. If a frame runs too long it cuts the transmitter off, raises a one-cycle jabber event, and keeps the channel disabled until a release condition is met. The length limit is counted either in bytes, using a bit-time tick, or in wall-clock time that depends on the line rate. Release is either immediate or delayed by a rate-dependent unjabber interval.

On the receive side it counts bit times while carrier sense is asserted. Carrier that lasts too long disables reception and raises a one-cycle watchdog event. Reception comes back after a programmable quiet period of bit times with carrier low. If carrier returns during the quiet period, the quiet count starts again. Each side has its own disable control that suppresses it entirely.

All time limits are expressed as parameters: clock cycles per 100 us, and counts of those units. A bench can therefore shorten them without changing the structure. The defaults give a 2304-byte cutoff, 30 ms and 3 ms jabber times, 400 ms and 40 ms unjabber times, and quiet periods of 20 and 44 bit times.

Top module: `jab_guard_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_cutoff`, `jab_event`, `rx_disable` and `rwd_event` are all 0.
- R2: With `jab_byte_mode`=1, `tx_cutoff` rises on the clock edge at which the JAB_BYTES*8-th cycle with both `tx_en`=1 and `bit_tick`=1 is sampled. Cycles with `bit_tick`=0 do not advance the count.
- R3: With `jab_byte_mode`=0, `tx_cutoff` rises after `tx_en` has been sampled high on a rate-dependent number of consecutive clock edges: JAB_FAST_UNITS*TICK_CYC when `rate_fast`=1 (100 Mb/s), or JAB_SLOW_UNITS*TICK_CYC when `rate_fast`=0 (10 Mb/s). This count does not depend on `bit_tick`.
- R4: `jab_event` is a single-cycle pulse that is high exactly in the cycle in which `tx_cutoff` rises, and at no other time.
- R5: With `host_unjab`=1, `tx_cutoff` falls on the first clock edge after the cutoff at which `tx_en` is sampled low.
- R6: With `host_unjab`=0, `tx_cutoff` stays high for UNJAB_FAST_UNITS*TICK_CYC edges (`rate_fast`=1) or UNJAB_SLOW_UNITS*TICK_CYC edges (`rate_fast`=0) after the cutoff edge. After that it falls on the first edge with `tx_en` low. While `tx_en` stays high, the cutoff is held.
- R7: While `jab_disable`=1, the transmit guard is held idle: `tx_cutoff` and `jab_event` stay 0 whatever `tx_en` does.
- R8: Sampling `tx_en` low before the cutoff point clears the transmit count. The next burst starts counting from zero.
- R9: `rx_disable` rises, together with a single-cycle `rwd_event`, on the edge at which the RWD_BYTES*8-th cycle with `crs`=1 and `bit_tick`=1 is sampled. Dropping `crs` earlier clears the count.
- R10: After a receive timeout, `rx_disable` falls after QUIET_SHORT (`rx_long_quiet`=0) or QUIET_LONG (`rx_long_quiet`=1) consecutive `bit_tick` cycles with `crs` low. Sampling `crs` high during that time restarts the quiet count from zero.
- R11: While `rwd_disable`=1, the receive guard is held idle: `rx_disable` and `rwd_event` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per line bit time |
| rate_fast | input | 1 | 1 = 100 Mb/s time limits, 0 = 10 Mb/s |
| jab_byte_mode | input | 1 | 1 = byte-count jabber, 0 = time-based jabber |
| host_unjab | input | 1 | 1 = release cutoff as soon as tx_en is low |
| jab_disable | input | 1 | 1 = transmit guard off |
| rwd_disable | input | 1 | 1 = receive guard off |
| rx_long_quiet | input | 1 | 1 = long quiet period before receive release |
| tx_en | input | 1 | MAC transmit enable |
| crs | input | 1 | Carrier sense |
| tx_cutoff | output | 1 | Transmit channel disabled |
| jab_event | output | 1 | Pulse: jabber cutoff occurred |
| rx_disable | output | 1 | Reception disabled |
| rwd_event | output | 1 | Pulse: receive watchdog timeout |

## Verification
The jabber cutoff and the receive watchdog timeout can fire on the same clock edge, because both count the same bit ticks. The bench provokes this by using equal byte limits and raising `tx_en` and `crs` in the same cycle under byte-mode jabber. It then expects both levels and both event pulses in that exact cycle. It also expects each side to release on its own schedule afterwards: the transmit side one edge after `tx_en` drops, and the receive side after the short quiet period.

// File: rtl/jab_guard_pkg.sv
package jab_guard_pkg;

    typedef enum logic {
        TXG_IDLE = 1'b0,
        TXG_CUT  = 1'b1
    } txg_state_e;

    typedef enum logic {
        RXG_IDLE = 1'b0,
        RXG_HOLD = 1'b1
    } rxg_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/jab_tx_guard.sv
module jab_tx_guard
    import jab_guard_pkg::*;
#(
    parameter int CW         = 16,
    parameter int BYTE_BITS  = 18432,
    parameter int JAB_SLOW   = 300,
    parameter int JAB_FAST   = 30,
    parameter int UNJAB_SLOW = 4000,
    parameter int UNJAB_FAST = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rate_fast,
    input  logic byte_mode,
    input  logic host_unjab,
    input  logic jab_dis,
    input  logic tx_en,
    output logic cutoff,
    output logic jab_event
);

    localparam logic [CW-1:0] L_BYTE = CW'(BYTE_BITS - 1);
    localparam logic [CW-1:0] L_JS   = CW'(JAB_SLOW - 1);
    localparam logic [CW-1:0] L_JF   = CW'(JAB_FAST - 1);
    localparam logic [CW-1:0] L_US   = CW'(UNJAB_SLOW - 1);
    localparam logic [CW-1:0] L_UF   = CW'(UNJAB_FAST - 1);

    typedef struct packed {
        txg_state_e    state;
        logic [CW-1:0] cnt;
        logic          evt;
    } tx_regs_t;

    tx_regs_t      cur_q, nxt_d;
    logic [CW-1:0] cut_lim;
    logic [CW-1:0] unj_lim;
    logic          step;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.evt = 1'b0;
        cut_lim   = byte_mode ? L_BYTE : (rate_fast ? L_JF : L_JS);
        unj_lim   = rate_fast ? L_UF : L_US;
        step      = byte_mode ? bit_tick : 1'b1;
        if (jab_dis) begin
            nxt_d = '{state: TXG_IDLE, cnt: '0, evt: 1'b0};
        end else begin
            case (cur_q.state)
                TXG_IDLE: begin
                    if (!tx_en) begin
                        nxt_d.cnt = '0;
                    end else if (step) begin
                        if (cur_q.cnt >= cut_lim) begin
                            nxt_d.state = TXG_CUT;
                            nxt_d.cnt   = '0;
                            nxt_d.evt   = 1'b1;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + CW'(1);
                        end
                    end
                end
                TXG_CUT: begin
                    if (!host_unjab && (cur_q.cnt < unj_lim)) begin
                        nxt_d.cnt = cur_q.cnt + CW'(1);
                    end
                    if ((host_unjab || (cur_q.cnt >= unj_lim)) && !tx_en) begin
                        nxt_d.state = TXG_IDLE;
                        nxt_d.cnt   = '0;
                    end
                end
                default: nxt_d = '{state: TXG_IDLE, cnt: '0, evt: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: TXG_IDLE, cnt: '0, evt: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cutoff    = (cur_q.state == TXG_CUT);
    assign jab_event = cur_q.evt;

endmodule

// File: rtl/jab_rx_guard.sv
module jab_rx_guard
    import jab_guard_pkg::*;
#(
    parameter int CW          = 16,
    parameter int RWD_BITS    = 18432,
    parameter int QUIET_SHORT = 20,
    parameter int QUIET_LONG  = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic crs,
    input  logic long_quiet,
    input  logic rwd_dis,
    output logic rx_off,
    output logic rwd_event
);

    localparam logic [CW-1:0] L_RWD = CW'(RWD_BITS - 1);
    localparam logic [CW-1:0] L_QS  = CW'(QUIET_SHORT - 1);
    localparam logic [CW-1:0] L_QL  = CW'(QUIET_LONG - 1);

    typedef struct packed {
        rxg_state_e    state;
        logic [CW-1:0] cnt;
        logic          evt;
    } rx_regs_t;

    rx_regs_t      cur_q, nxt_d;
    logic [CW-1:0] q_lim;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.evt = 1'b0;
        q_lim     = long_quiet ? L_QL : L_QS;
        if (rwd_dis) begin
            nxt_d = '{state: RXG_IDLE, cnt: '0, evt: 1'b0};
        end else begin
            case (cur_q.state)
                RXG_IDLE: begin
                    if (!crs) begin
                        nxt_d.cnt = '0;
                    end else if (bit_tick) begin
                        if (cur_q.cnt >= L_RWD) begin
                            nxt_d.state = RXG_HOLD;
                            nxt_d.cnt   = '0;
                            nxt_d.evt   = 1'b1;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + CW'(1);
                        end
                    end
                end
                RXG_HOLD: begin
                    if (crs) begin
                        nxt_d.cnt = '0;
                    end else if (bit_tick) begin
                        if (cur_q.cnt >= q_lim) begin
                            nxt_d.state = RXG_IDLE;
                            nxt_d.cnt   = '0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + CW'(1);
                        end
                    end
                end
                default: nxt_d = '{state: RXG_IDLE, cnt: '0, evt: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: RXG_IDLE, cnt: '0, evt: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rx_off    = (cur_q.state == RXG_HOLD);
    assign rwd_event = cur_q.evt;

endmodule

// File: rtl/jab_guard_top.sv
module jab_guard_top
    import jab_guard_pkg::*;
#(
    parameter int TICK_CYC         = 12500,
    parameter int JAB_BYTES        = 2304,
    parameter int RWD_BYTES        = 2304,
    parameter int JAB_SLOW_UNITS   = 300,
    parameter int JAB_FAST_UNITS   = 30,
    parameter int UNJAB_SLOW_UNITS = 4000,
    parameter int UNJAB_FAST_UNITS = 400,
    parameter int QUIET_SHORT      = 20,
    parameter int QUIET_LONG       = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rate_fast,
    input  logic jab_byte_mode,
    input  logic host_unjab,
    input  logic jab_disable,
    input  logic rwd_disable,
    input  logic rx_long_quiet,
    input  logic tx_en,
    input  logic crs,
    output logic tx_cutoff,
    output logic jab_event,
    output logic rx_disable,
    output logic rwd_event
);

    localparam int JB_BITS = JAB_BYTES * 8;
    localparam int RW_BITS = RWD_BYTES * 8;
    localparam int JS_CYC  = JAB_SLOW_UNITS * TICK_CYC;
    localparam int JF_CYC  = JAB_FAST_UNITS * TICK_CYC;
    localparam int US_CYC  = UNJAB_SLOW_UNITS * TICK_CYC;
    localparam int UF_CYC  = UNJAB_FAST_UNITS * TICK_CYC;
    localparam int TX_MAX  = imax(imax(JB_BITS, JS_CYC), imax(JF_CYC, imax(US_CYC, UF_CYC)));
    localparam int RX_MAX  = imax(RW_BITS, imax(QUIET_SHORT, QUIET_LONG));
    localparam int TX_CW   = $clog2(TX_MAX + 1);
    localparam int RX_CW   = $clog2(RX_MAX + 1);

    jab_tx_guard #(
        .CW         (TX_CW),
        .BYTE_BITS  (JB_BITS),
        .JAB_SLOW   (JS_CYC),
        .JAB_FAST   (JF_CYC),
        .UNJAB_SLOW (US_CYC),
        .UNJAB_FAST (UF_CYC)
    ) tx_guard_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rate_fast  (rate_fast),
        .byte_mode  (jab_byte_mode),
        .host_unjab (host_unjab),
        .jab_dis    (jab_disable),
        .tx_en      (tx_en),
        .cutoff     (tx_cutoff),
        .jab_event  (jab_event)
    );

    jab_rx_guard #(
        .CW          (RX_CW),
        .RWD_BITS    (RW_BITS),
        .QUIET_SHORT (QUIET_SHORT),
        .QUIET_LONG  (QUIET_LONG)
    ) rx_guard_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .crs        (crs),
        .long_quiet (rx_long_quiet),
        .rwd_dis    (rwd_disable),
        .rx_off     (rx_disable),
        .rwd_event  (rwd_event)
    );

endmodule

// File: rtl/jab_guard_chk.sv
module jab_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic crs,
    input logic host_unjab,
    input logic jab_disable,
    input logic rwd_disable,
    input logic tx_cutoff,
    input logic jab_event,
    input logic rx_disable,
    input logic rwd_event
);

    p_jev_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jab_event |=> !jab_event);

    p_jev_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_cutoff) |-> jab_event);

    p_jev_needs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jab_event |-> $rose(tx_cutoff));

    p_imm_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cutoff && host_unjab && !tx_en) |=> !tx_cutoff);

    p_hold_while_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cutoff && tx_en && !jab_disable) |=> tx_cutoff);

    p_jab_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jab_disable |=> (!tx_cutoff && !jab_event));

    p_rev_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rwd_event |=> !rwd_event);

    p_rev_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_disable) |-> rwd_event);

    p_rx_hold_carrier_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_disable && crs && !rwd_disable) |=> rx_disable);

    p_rwd_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rwd_disable |=> (!rx_disable && !rwd_event));

endmodule

bind jab_guard_top jab_guard_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .crs         (crs),
    .host_unjab  (host_unjab),
    .jab_disable (jab_disable),
    .rwd_disable (rwd_disable),
    .tx_cutoff   (tx_cutoff),
    .jab_event   (jab_event),
    .rx_disable  (rx_disable),
    .rwd_event   (rwd_event)
);

// File: tb/jab_guard_top_tb_top.sv
module jab_guard_top_tb_top;

    localparam int S_CUT = 0;
    localparam int S_JEV = 1;
    localparam int S_RXD = 2;
    localparam int S_REV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic rate_fast = 1'b0;
    logic jab_byte_mode = 1'b1;
    logic host_unjab = 1'b1;
    logic jab_disable = 1'b0;
    logic rwd_disable = 1'b0;
    logic rx_long_quiet = 1'b0;
    logic tx_en = 1'b0;
    logic crs = 1'b0;
    logic tx_cutoff, jab_event, rx_disable, rwd_event;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    cyc;
        int    sig;
        logic  val;
        string tag;
    } exp_t;

    exp_t exq[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    jab_guard_top #(
        .TICK_CYC         (2),
        .JAB_BYTES        (4),
        .RWD_BYTES        (4),
        .JAB_SLOW_UNITS   (300),
        .JAB_FAST_UNITS   (30),
        .UNJAB_SLOW_UNITS (4000),
        .UNJAB_FAST_UNITS (400),
        .QUIET_SHORT      (20),
        .QUIET_LONG       (44)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .rate_fast     (rate_fast),
        .jab_byte_mode (jab_byte_mode),
        .host_unjab    (host_unjab),
        .jab_disable   (jab_disable),
        .rwd_disable   (rwd_disable),
        .rx_long_quiet (rx_long_quiet),
        .tx_en         (tx_en),
        .crs           (crs),
        .tx_cutoff     (tx_cutoff),
        .jab_event     (jab_event),
        .rx_disable    (rx_disable),
        .rwd_event     (rwd_event)
    );

    function automatic logic sig_val(input int s);
        case (s)
            S_CUT:   return tx_cutoff;
            S_JEV:   return jab_event;
            S_RXD:   return rx_disable;
            default: return rwd_event;
        endcase
    endfunction

    task automatic check(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic expect_at(input int c, input int s, input logic v, input string tag);
        exp_t e;
        e.cyc = c;
        e.sig = s;
        e.val = v;
        e.tag = tag;
        exq.push_back(e);
    endtask

    // monitor: compares queued expectations in their cycle
    always @(negedge clk) begin
        exp_t e;
        while (exq.size() > 0 && exq[0].cyc <= cyc) begin
            e = exq.pop_front();
            check(sig_val(e.sig), e.val, e.tag);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (exq.size() > 0) @(negedge clk);
        wait_n(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        int e0;
        wait_n(3);
        // R1: outputs quiet in reset and just after it
        check(tx_cutoff, 1'b0, "R1 cutoff in reset");
        check(rx_disable, 1'b0, "R1 rx_disable in reset");
        rst_n = 1'b1;
        wait_n(1);
        check(tx_cutoff, 1'b0, "R1 cutoff after reset");
        check(jab_event, 1'b0, "R1 jab_event after reset");
        check(rx_disable, 1'b0, "R1 rx_disable after reset");
        check(rwd_event, 1'b0, "R1 rwd_event after reset");

        // R2 R4 R5: byte cutoff, immediate release
        c0 = cyc;
        jab_byte_mode = 1'b1; host_unjab = 1'b1; tx_en = 1'b1;
        expect_at(c0 + 31, S_CUT, 1'b0, "R2 no cutoff before limit");
        expect_at(c0 + 32, S_CUT, 1'b1, "R2 cutoff at byte limit");
        expect_at(c0 + 32, S_JEV, 1'b1, "R4 event with cutoff");
        expect_at(c0 + 33, S_JEV, 1'b0, "R4 event one cycle");
        expect_at(c0 + 40, S_CUT, 1'b1, "R5 held while tx_en");
        expect_at(c0 + 41, S_CUT, 1'b0, "R5 immediate release");
        wait_n(40);
        tx_en = 1'b0;
        drain();

        // R8: short bursts do not accumulate
        c0 = cyc;
        tx_en = 1'b1;
        expect_at(c0 + 20, S_CUT, 1'b0, "R8 first burst");
        expect_at(c0 + 43, S_CUT, 1'b0, "R8 count cleared between bursts");
        expect_at(c0 + 43, S_JEV, 1'b0, "R8 no event");
        wait_n(20);
        tx_en = 1'b0;
        wait_n(3);
        tx_en = 1'b1;
        wait_n(20);
        tx_en = 1'b0;
        drain();

        // R2: byte count advances only on bit_tick
        c0 = cyc;
        tx_en = 1'b1; bit_tick = 1'b1;
        expect_at(c0 + 62, S_CUT, 1'b0, "R2 sparse ticks before limit");
        expect_at(c0 + 63, S_CUT, 1'b1, "R2 sparse ticks at limit");
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            bit_tick = ~bit_tick;
        end
        tx_en = 1'b0; bit_tick = 1'b1;
        drain();

        // R3 R6: time-based, fast rate, delayed release
        c0 = cyc;
        e0 = c0 + 60;
        jab_byte_mode = 1'b0; rate_fast = 1'b1; host_unjab = 1'b0;
        bit_tick = 1'b0; tx_en = 1'b1;
        expect_at(c0 + 59, S_CUT, 1'b0, "R3 fast before time limit");
        expect_at(e0, S_CUT, 1'b1, "R3 fast time cutoff");
        expect_at(e0 + 799, S_CUT, 1'b1, "R6 fast unjab not yet");
        expect_at(e0 + 800, S_CUT, 1'b0, "R6 fast unjab release");
        wait_n(70);
        tx_en = 1'b0;
        wait_n(795);
        drain();

        // R3 R6: slow rate, release waits for tx_en low
        c0 = cyc;
        e0 = c0 + 600;
        rate_fast = 1'b0; tx_en = 1'b1;
        expect_at(c0 + 599, S_CUT, 1'b0, "R3 slow before time limit");
        expect_at(e0, S_CUT, 1'b1, "R3 slow time cutoff");
        expect_at(e0 + 8005, S_CUT, 1'b1, "R6 held past unjab while tx_en");
        expect_at(e0 + 8006, S_CUT, 1'b0, "R6 release once tx_en low");
        wait_n(8605);
        tx_en = 1'b0;
        drain();
        bit_tick = 1'b1;

        // R7: jabber disabled
        c0 = cyc;
        jab_byte_mode = 1'b1; host_unjab = 1'b1; jab_disable = 1'b1; tx_en = 1'b1;
        expect_at(c0 + 32, S_CUT, 1'b0, "R7 no cutoff when disabled");
        expect_at(c0 + 32, S_JEV, 1'b0, "R7 no event when disabled");
        expect_at(c0 + 50, S_CUT, 1'b0, "R7 still no cutoff");
        wait_n(50);
        tx_en = 1'b0; jab_disable = 1'b0;
        drain();

        // R9 R10: receive timeout, short quiet
        c0 = cyc;
        rx_long_quiet = 1'b0; crs = 1'b1;
        expect_at(c0 + 31, S_RXD, 1'b0, "R9 before carrier limit");
        expect_at(c0 + 32, S_RXD, 1'b1, "R9 carrier timeout");
        expect_at(c0 + 32, S_REV, 1'b1, "R9 watchdog event");
        expect_at(c0 + 33, S_REV, 1'b0, "R9 event one cycle");
        expect_at(c0 + 59, S_RXD, 1'b1, "R10 short quiet not yet");
        expect_at(c0 + 60, S_RXD, 1'b0, "R10 short quiet release");
        wait_n(40);
        crs = 1'b0;
        drain();

        // R10: long quiet, carrier glitch restarts count
        c0 = cyc;
        rx_long_quiet = 1'b1; crs = 1'b1;
        expect_at(c0 + 32, S_RXD, 1'b1, "R9 carrier timeout long");
        expect_at(c0 + 84, S_RXD, 1'b1, "R10 quiet restarted by carrier");
        expect_at(c0 + 108, S_RXD, 1'b1, "R10 long quiet not yet");
        expect_at(c0 + 109, S_RXD, 1'b0, "R10 long quiet release");
        wait_n(40);
        crs = 1'b0;
        wait_n(20);
        crs = 1'b1;
        wait_n(5);
        crs = 1'b0;
        drain();

        // R11: watchdog disabled
        c0 = cyc;
        rwd_disable = 1'b1; crs = 1'b1;
        expect_at(c0 + 32, S_RXD, 1'b0, "R11 no timeout when disabled");
        expect_at(c0 + 32, S_REV, 1'b0, "R11 no event when disabled");
        expect_at(c0 + 50, S_RXD, 1'b0, "R11 still enabled");
        wait_n(50);
        crs = 1'b0; rwd_disable = 1'b0;
        drain();

        // R2 R9 together: both guards fire on one edge
        c0 = cyc;
        rx_long_quiet = 1'b0; tx_en = 1'b1; crs = 1'b1;
        expect_at(c0 + 32, S_CUT, 1'b1, "R2 same-edge cutoff");
        expect_at(c0 + 32, S_JEV, 1'b1, "R4 same-edge jab event");
        expect_at(c0 + 32, S_RXD, 1'b1, "R9 same-edge rx timeout");
        expect_at(c0 + 32, S_REV, 1'b1, "R9 same-edge rwd event");
        expect_at(c0 + 41, S_CUT, 1'b0, "R5 same-edge tx release");
        expect_at(c0 + 59, S_RXD, 1'b1, "R10 same-edge rx hold");
        expect_at(c0 + 60, S_RXD, 1'b0, "R10 same-edge rx release");
        wait_n(40);
        tx_en = 1'b0; crs = 1'b0;
        drain();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule